// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block holds the interrupt status flags of a CAN controller and drives four interrupt request lines: transmit, receive, wake-up and error. It watches level and pulse conditions from the rest of the controller: one empty indication per transmit buffer, an end-of-frame pulse for each received message, bus activity seen during internal sleep, and the error-state levels (error passive, warning, bus-off). A small receive queue model tracks how many received messages wait behind the foreground slot. A receive FIFO overrun raises its own error flag.

Software clears flags through a write-one-to-clear port. A clear has no effect while the condition behind the flag is still present. If a condition and a clear land in the same cycle, the flag stays set. Clearing the receive flag releases the foreground message. If more messages are waiting, the receive flag drops for one cycle and then sets again as the next message moves forward. Each interrupt line is asserted while any of its flags is set and its enable bit is high.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. A receive queue that is full drops the arriving message and reports an overrun.

Top module: `can_irq_flags`

## Requirements
- R1: After reset every flag in `flags_o` and every line of `irq_o` is 0, and the receive queue is empty.
- R2: Flag bit i (0 to NUM_TX-1) sets on the clock edge where `tx_empty_i[i]` is high. A clear of that bit is ignored while `tx_empty_i[i]` stays high.
- R3: With `wr_en_i` high, a 1 in `wr_data_i` clears the matching flag when its condition is absent. A 0 bit, or any data with `wr_en_i` low, leaves the flags unchanged.
- R4: When a set condition and a clear of the same flag arrive at the same edge, the flag is set after that edge.
- R5: The receive flag (bit NUM_TX) sets on the edge after `rx_eof_i` when it was clear.
- R6: Clearing a set receive flag releases the foreground message, and the flag reads 0 after that edge. If messages remain queued, the flag sets again on the following edge.
- R7: The receive queue holds RX_DEPTH (default 3) messages. An `rx_eof_i` while the queue is full and no release happens in that cycle drops the message and sets the overrun flag (bit NUM_TX+2).
- R8: The wake-up flag (bit NUM_TX+1) sets only when `sleep_i` and `bus_act_i` are both high. Bus activity outside sleep is ignored.
- R9: The error-passive, warning and bus-off flags (bits NUM_TX+3, NUM_TX+4 and NUM_TX+5) set from the levels `err_passive_i`, `warn_i` and `busoff_i`.
- R10: `irq_o` has four lines: [0] transmit, the OR of the transmit flags; [1] receive; [2] wake-up; [3] error, the OR of bits NUM_TX+2 to NUM_TX+5. Each line is ANDed with its bit of `irq_en_i` and follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_empty_i | input | NUM_TX | Empty level per transmit buffer |
| rx_eof_i | input | 1 | One-cycle pulse: message received and complete |
| sleep_i | input | 1 | Controller is in internal sleep |
| bus_act_i | input | 1 | Activity seen on the bus |
| err_passive_i | input | 1 | Error-passive level |
| warn_i | input | 1 | Error warning level |
| busoff_i | input | 1 | Bus-off level |
| wr_en_i | input | 1 | Write strobe for the clear port |
| wr_data_i | input | NUM_TX+6 | Write-one-to-clear mask, one bit per flag |
| irq_en_i | input | 4 | Enable per interrupt line |
| flags_o | output | NUM_TX+6 | Flag register |
| irq_o | output | 4 | Interrupt request lines |

## Verification
Inputs change 1 ns after a rising edge. Every flag is due exactly one edge later, and the interrupt lines are due in that same cycle because they are combinational from the flags. The one exception is the receive flag after a release with messages still queued: it reads 0 one edge after the clear and 1 the edge after that. The bench advances its own model once per edge and compares every flag and line 1 ns after the edge, so each result is checked in the cycle it is due and never earlier or later.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_IRQ  = 4;
  localparam int NUM_ERRF = 4;

  typedef enum logic [1:0] {
    IRQ_TX   = 2'd0,
    IRQ_RX   = 2'd1,
    IRQ_WAKE = 2'd2,
    IRQ_ERR  = 2'd3
  } irq_line_e;

  function automatic int flag_width(input int ntx);
    return ntx + 2 + NUM_ERRF;
  endfunction

  function automatic int rx_bit(input int ntx);
    return ntx;
  endfunction

  function automatic int wake_bit(input int ntx);
    return ntx + 1;
  endfunction

  function automatic int err_base(input int ntx);
    return ntx + 2;
  endfunction
endpackage

// File: rtl/can_irq_w1c_bank.sv
module can_irq_w1c_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (cond_i[i]) flag_q <= 1'b1;   // set wins over clear
      else if (clr_i[i])  flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/can_irq_rx_queue.sv
module can_irq_rx_queue #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eof_i,
  input  logic clr_i,
  output logic flag_o,
  output logic overrun_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          pop, full, accept;

  assign pop       = clr_i && flag_q;
  assign full      = (cnt_q == FULL);
  assign overrun_o = eof_i && full && !pop;
  assign accept    = eof_i && !overrun_o;

  always_comb begin
    cnt_d = cnt_q;
    if (accept && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!accept && pop) cnt_d = cnt_q - 1'b1;
    // a release shows a cleared flag for one cycle before the next message
    flag_d = !pop && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_irq_combiner.sv
module can_irq_combiner
  import can_irq_pkg::*;
#(
  parameter int NUM_TX = 3,
  localparam int FW = flag_width(NUM_TX)
) (
  input  logic [FW-1:0]      flags_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int RXB = rx_bit(NUM_TX);
  localparam int WKB = wake_bit(NUM_TX);
  localparam int EB  = err_base(NUM_TX);

  logic [NUM_IRQ-1:0] pend;

  always_comb begin
    pend           = '0;
    pend[IRQ_TX]   = |flags_i[NUM_TX-1:0];
    pend[IRQ_RX]   = flags_i[RXB];
    pend[IRQ_WAKE] = flags_i[WKB];
    pend[IRQ_ERR]  = |flags_i[EB +: NUM_ERRF];
  end

  assign irq_o = pend & en_i;
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int NUM_TX   = 3,
  parameter int RX_DEPTH = 3,
  localparam int FW = flag_width(NUM_TX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TX-1:0]  tx_empty_i,
  input  logic               rx_eof_i,
  input  logic               sleep_i,
  input  logic               bus_act_i,
  input  logic               err_passive_i,
  input  logic               warn_i,
  input  logic               busoff_i,
  input  logic               wr_en_i,
  input  logic [FW-1:0]      wr_data_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic [FW-1:0]      flags_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int RXB  = rx_bit(NUM_TX);
  localparam int WKB  = wake_bit(NUM_TX);
  localparam int EB   = err_base(NUM_TX);
  localparam int NLVL = NUM_TX + 1 + NUM_ERRF;   // flags in the generic bank

  logic [FW-1:0]   clr;
  logic            rx_flag, overrun;
  logic [NLVL-1:0] lvl_cond, lvl_clr, lvl_flag;

  assign clr = wr_en_i ? wr_data_i : '0;

  can_irq_rx_queue #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .eof_i     (rx_eof_i),
    .clr_i     (clr[RXB]),
    .flag_o    (rx_flag),
    .overrun_o (overrun)
  );

  // bank order: tx flags, wake, overrun, passive, warning, bus-off
  assign lvl_cond = {busoff_i, warn_i, err_passive_i, overrun,
                     sleep_i && bus_act_i, tx_empty_i};
  assign lvl_clr  = {clr[EB +: NUM_ERRF], clr[WKB], clr[NUM_TX-1:0]};

  can_irq_w1c_bank #(.N(NLVL)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (lvl_cond),
    .clr_i  (lvl_clr),
    .flag_o (lvl_flag)
  );

  assign flags_o = {lvl_flag[NLVL-1 -: NUM_ERRF], lvl_flag[NUM_TX], rx_flag,
                    lvl_flag[NUM_TX-1:0]};

  can_irq_combiner #(.NUM_TX(NUM_TX)) u_comb (
    .flags_i (flags_o),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_TX = 3,
  localparam int FW = flag_width(NUM_TX)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_TX-1:0]  tx_empty_i,
  input logic               rx_eof_i,
  input logic               sleep_i,
  input logic               bus_act_i,
  input logic               wr_en_i,
  input logic [FW-1:0]      wr_data_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic [FW-1:0]      flags_o,
  input logic [NUM_IRQ-1:0] irq_o
);
  localparam int RXB = rx_bit(NUM_TX);
  localparam int WKB = wake_bit(NUM_TX);
  localparam int OVB = err_base(NUM_TX);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_i[0] |=> flags_o[0]);

  assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[WKB] && !(sleep_i && bus_act_i)) |=> !flags_o[WKB]);

  assert_rx_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof_i && !flags_o[RXB]) |=> flags_o[RXB]);

  assert_rx_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[RXB] && flags_o[RXB]) |=> !flags_o[RXB]);

  assert_overrun_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[OVB]) |-> $past(rx_eof_i));

  assert_wake_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[WKB]) |-> $past(sleep_i && bus_act_i));

  assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~irq_en_i) == '0);
endmodule

bind can_irq_flags can_irq_flags_chk #(.NUM_TX(NUM_TX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_empty_i (tx_empty_i),
  .rx_eof_i   (rx_eof_i),
  .sleep_i    (sleep_i),
  .bus_act_i  (bus_act_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .irq_en_i   (irq_en_i),
  .flags_o    (flags_o),
  .irq_o      (irq_o)
);

// File: tb/can_irq_flags_tb.sv
module can_irq_flags_tb;
  localparam int NTX = 3;
  localparam int FW  = NTX + 6;
  localparam int RXB = 3, WKB = 4, OVB = 5, EPB = 6, WNB = 7, BOB = 8;
  localparam int DEPTH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NTX-1:0] tx_empty = '0;
  logic eof = 0, sleep = 0, act = 0, ep = 0, warn = 0, boff = 0, wen = 0;
  logic [FW-1:0] wdata = '0;
  logic [3:0] en = 4'hF;
  logic [FW-1:0] flags;
  logic [3:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [FW-1:0] ef = '0;
  int ecnt = 0;

  always #5 clk = ~clk;

  can_irq_flags #(.NUM_TX(NTX), .RX_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_empty_i(tx_empty), .rx_eof_i(eof),
    .sleep_i(sleep), .bus_act_i(act), .err_passive_i(ep), .warn_i(warn),
    .busoff_i(boff), .wr_en_i(wen), .wr_data_i(wdata), .irq_en_i(en),
    .flags_o(flags), .irq_o(irq)
  );

  function automatic logic [3:0] exp_irq(input logic [FW-1:0] f, input logic [3:0] m);
    return {|f[BOB:OVB], f[WKB], f[RXB], |f[NTX-1:0]} & m;
  endfunction

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  // advance the model by one edge from the driven inputs, then compare
  task automatic step();
    logic [FW-1:0] c, n;
    logic pop, ovr, acc;
    int cn;
    c   = wen ? wdata : '0;
    pop = c[RXB] && ef[RXB];
    ovr = eof && (ecnt == DEPTH) && !pop;
    acc = eof && !ovr;
    cn  = ecnt + int'(acc) - int'(pop);
    n = ef;
    for (int i = 0; i < FW; i++) if (c[i]) n[i] = 1'b0;
    n[NTX-1:0] |= tx_empty;
    n[WKB] |= sleep && act;
    n[OVB] |= ovr;
    n[EPB] |= ep;
    n[WNB] |= warn;
    n[BOB] |= boff;
    n[RXB] = !pop && (cn != 0);
    @(posedge clk); #1;
    ef = n; ecnt = cn;
    chk("R2 tx flags", int'(flags[NTX-1:0]), int'(ef[NTX-1:0]));
    chk("R6 rx flag", int'(flags[RXB]), int'(ef[RXB]));
    chk("R8 wake flag", int'(flags[WKB]), int'(ef[WKB]));
    chk("R7 overrun flag", int'(flags[OVB]), int'(ef[OVB]));
    chk("R9 error flags", int'(flags[BOB:EPB]), int'(ef[BOB:EPB]));
    chk("R10 irq lines", int'(irq), int'(exp_irq(ef, en)));
  endtask

  task automatic idle();
    tx_empty = '0; eof = 0; sleep = 0; act = 0; ep = 0; warn = 0; boff = 0;
    wen = 0; wdata = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flags", int'(flags), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    step();
    chk("R1 rx idle after reset", int'(flags[RXB]), 0);

    // transmit flag set, clear ignored while empty persists
    tx_empty = 3'b001; step();
    chk("R2 tx0 set", int'(flags[0]), 1);
    chk("R10 tx irq", int'(irq[0]), 1);
    wen = 1; wdata = 9'h001; step();
    chk("R2 clear ignored while empty", int'(flags[0]), 1);
    tx_empty = '0; wdata = 9'h000; step();
    chk("R3 zero write no effect", int'(flags[0]), 1);
    wen = 0; wdata = '1; step();
    chk("R3 no strobe no effect", int'(flags[0]), 1);
    en = 4'h0; step();
    chk("R10 masked tx line", int'(irq[0]), 0);
    en = 4'hF;
    wen = 1; wdata = 9'h001; step();
    chk("R3 clear done", int'(flags[0]), 0);
    chk("R10 tx line drops", int'(irq[0]), 0);
    idle();

    // same-cycle set and clear
    warn = 1; step();
    warn = 1; wen = 1; wdata = 9'h080; step();
    chk("R4 set wins over clear", int'(flags[WNB]), 1);
    idle(); wen = 1; wdata = 9'h080; step();
    chk("R3 warn cleared", int'(flags[WNB]), 0);
    idle();

    // receive queue fill, overrun, drain
    eof = 1; step();
    chk("R5 rx flag after eof", int'(flags[RXB]), 1);
    step(); step();
    chk("R7 no overrun at depth", int'(flags[OVB]), 0);
    step();
    chk("R7 overrun when full", int'(flags[OVB]), 1);
    chk("R10 error line", int'(irq[3]), 1);
    idle(); wen = 1; wdata = 9'h008; step();
    chk("R6 release drops flag", int'(flags[RXB]), 0);
    idle(); step();
    chk("R6 next message raises flag", int'(flags[RXB]), 1);
    wen = 1; wdata = 9'h008; step(); idle(); step();
    wen = 1; wdata = 9'h008; step(); idle(); step();
    chk("R7 dropped message not queued", int'(flags[RXB]), 0);
    wen = 1; wdata = 9'h020; step(); idle();

    // wake-up
    act = 1; step();
    chk("R8 activity outside sleep ignored", int'(flags[WKB]), 0);
    sleep = 1; act = 1; step();
    chk("R8 wake flag", int'(flags[WKB]), 1);
    chk("R10 wake line", int'(irq[2]), 1);
    idle();

    // error levels
    ep = 1; boff = 1; step();
    chk("R9 passive and bus-off", int'(flags[BOB:EPB]), 3'b101);
    idle(); wen = 1; wdata = '1; step(); idle();

    // constrained random phase
    for (int k = 0; k < 3000; k++) begin
      tx_empty = ($urandom_range(3) == 0) ? NTX'($urandom) : '0;
      eof   = ($urandom_range(3) == 0);
      sleep = ($urandom_range(1) == 0);
      act   = ($urandom_range(3) == 0);
      ep    = ($urandom_range(7) == 0);
      warn  = ($urandom_range(7) == 0);
      boff  = ($urandom_range(15) == 0);
      wen   = ($urandom_range(1) == 0);
      wdata = FW'($urandom);
      en    = 4'($urandom);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule